// File: doc/BRIEF.md
# Reloading Down-Counter Timer Bank

This block holds three independent down-counting timers behind one synchronous register port. Two timers are 16 bits wide and the third is 32 bits wide. Each timer has a load, value, control and clear register. When a timer is enabled, it steps down by one on each pulse of the tick enable that its control word selects. The selection is between a fast tick and a slow tick, both produced outside the block. A tick that arrives while the count is zero is an underflow. On an underflow the timer raises its own interrupt line. It then either reloads from its load register (periodic mode) or wraps to all ones (free-run mode).

Software arms a countdown in three steps. It writes 0 to the control register, writes the start value to the load register, and then writes the control word with the enable bit set. The interrupt stays asserted until software writes any value to that timer's clear register.

Top module: `tmr_bank`

## Requirements
- R1: After reset all load values, counts and control words are zero, and all three interrupt lines are low.
- R2: Timers 0, 1 and 2 are based at byte addresses 0x00, 0x20 and 0x80. Within a timer, offset +0x0 is load, +0x4 is value, +0x8 is control and +0xC is clear. The read data for a request with rd_en appears on rdata in the following cycle.
- R3: Timers 0 and 1 hold 16-bit counts and timer 2 holds a 32-bit count. The value and load registers read back zero-extended to 32 bits.
- R4: A write to the load register sets both the reload value and the live count. If it coincides with a tick, the written value wins.
- R5: In the control word, bit 7 enables counting, bit 6 selects periodic mode and bit 3 selects the fast tick (0 selects the slow tick). A read of the control register returns only these three bits, and all other bits read as 0.
- R6: An enabled timer decrements by one on each pulse of its selected tick. A disabled timer, or a pulse on the unselected tick, leaves the count unchanged.
- R7: In periodic mode, a selected tick at count zero reloads the count from the load register and sets the interrupt. For a load value L the interrupt fires after L+1 ticks.
- R8: In free-run mode, a selected tick at count zero wraps the count to all ones (0xFFFF for the 16-bit timers, 0xFFFFFFFF for timer 2) and sets the interrupt.
- R9: A write of any data value to a timer's clear register drops that timer's interrupt one cycle later and leaves the other interrupts unchanged. Without a clear, a pending interrupt stays high.
- R10: If a clear write and an underflow of the same timer fall in the same cycle, the interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| tick_fast | input | 1 | Fast tick enable pulse |
| tick_slow | input | 1 | Slow tick enable pulse |
| irq | output | 3 | Per-timer pending underflow interrupt |

## Verification
For every timer, load values 0 to 5 are swept in periodic mode. The count is checked one tick before underflow and again after it, which separates an off-by-one period from a missing reload. A free-run countdown on each timer distinguishes a wrap to the timer's own all-ones width from a reload. Stepping the fast and slow ticks with each clock select, and with counting disabled, separates a correct tick choice from a swapped or ignored one. Same-cycle collisions (clear with underflow, load with tick), together with clearing one of two pending timers, decide the priority and independence rules.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_TMR = 3;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 8;

    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_PER_BIT  = 6;
    localparam int CTRL_FAST_BIT = 3;

    typedef struct packed {
        logic en;
        logic periodic;
        logic fast;
    } tmr_ctrl_t;

    // register selected by address bits [3:2] inside a timer window
    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_VALUE = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } tmr_reg_e;

    function automatic tmr_ctrl_t ctrl_unpack(input logic [BUS_W-1:0] d);
        tmr_ctrl_t c;
        c.en       = d[CTRL_EN_BIT];
        c.periodic = d[CTRL_PER_BIT];
        c.fast     = d[CTRL_FAST_BIT];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_pack(input tmr_ctrl_t c);
        logic [BUS_W-1:0] d;
        d                = '0;
        d[CTRL_EN_BIT]   = c.en;
        d[CTRL_PER_BIT]  = c.periodic;
        d[CTRL_FAST_BIT] = c.fast;
        return d;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             load_wr,
    input  logic             ctrl_wr,
    input  logic             clr_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] load_ext,
    output logic [BUS_W-1:0] cnt_ext,
    output tmr_ctrl_t        ctrl_o,
    output logic             irq_o,
    output logic             uf_o
);

    typedef struct packed {
        logic [WIDTH-1:0] load;
        logic [WIDTH-1:0] cnt;
        tmr_ctrl_t        ctrl;
        logic             irq;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     tick_sel;
    logic     step;
    logic     at_zero;

    always_comb begin
        tick_sel = st_q.ctrl.fast ? tick_fast : tick_slow;
        step     = st_q.ctrl.en && tick_sel;
        at_zero  = (st_q.cnt == '0);
        uf_o     = step && at_zero && !load_wr;

        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl = ctrl_unpack(wdata);
        end
        if (load_wr) begin
            st_d.load = wdata[WIDTH-1:0];
            st_d.cnt  = wdata[WIDTH-1:0];
        end else if (step) begin
            if (at_zero) begin
                st_d.cnt = st_q.ctrl.periodic ? st_q.load : '1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (uf_o) begin
            st_d.irq = 1'b1;
        end else if (clr_wr) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        load_ext             = '0;
        load_ext[WIDTH-1:0]  = st_q.load;
        cnt_ext              = '0;
        cnt_ext[WIDTH-1:0]   = st_q.cnt;
        ctrl_o               = st_q.ctrl;
        irq_o                = st_q.irq;
    end

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter logic [NUM_TMR*ADDR_W-1:0] BASES = {8'h80, 8'h20, 8'h00}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BUS_W-1:0]              wdata,
    input  logic [NUM_TMR-1:0][BUS_W-1:0] load_rd,
    input  logic [NUM_TMR-1:0][BUS_W-1:0] cnt_rd,
    input  tmr_ctrl_t [NUM_TMR-1:0]       ctrl_rd,
    output logic [NUM_TMR-1:0]            load_wr,
    output logic [NUM_TMR-1:0]            ctrl_wr,
    output logic [NUM_TMR-1:0]            clr_wr,
    output logic [BUS_W-1:0]              rdata
);

    localparam int WIN_LSB = 4;
    localparam int WIN_W   = ADDR_W - WIN_LSB;

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } rif_st_t;

    rif_st_t            st_d, st_q;
    logic [NUM_TMR-1:0] hit;
    tmr_reg_e           reg_sel;

    always_comb begin
        reg_sel = tmr_reg_e'(addr[3:2]);
        for (int i = 0; i < NUM_TMR; i++) begin
            hit[i]     = (addr[ADDR_W-1:WIN_LSB] == BASES[i*ADDR_W+WIN_LSB +: WIN_W])
                         && (addr[1:0] == 2'b00);
            load_wr[i] = wr_en && hit[i] && (reg_sel == REG_LOAD);
            ctrl_wr[i] = wr_en && hit[i] && (reg_sel == REG_CTRL);
            clr_wr[i]  = wr_en && hit[i] && (reg_sel == REG_CLEAR);
        end

        st_d = st_q;
        if (rd_en) begin
            st_d.rdata = '0;
            for (int i = 0; i < NUM_TMR; i++) begin
                if (hit[i]) begin
                    case (reg_sel)
                        REG_LOAD:  st_d.rdata = load_rd[i];
                        REG_VALUE: st_d.rdata = cnt_rd[i];
                        REG_CTRL:  st_d.rdata = ctrl_pack(ctrl_rd[i]);
                        default:   st_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int                          SMALL_W = 16,
    parameter int                          LARGE_W = 32,
    parameter int                          WIDE_IX = 2,
    parameter logic [NUM_TMR*ADDR_W-1:0]   BASES   = {8'h80, 8'h20, 8'h00}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    output logic [BUS_W-1:0]    rdata,
    input  logic                tick_fast,
    input  logic                tick_slow,
    output logic [NUM_TMR-1:0]  irq
);

    logic [NUM_TMR-1:0][BUS_W-1:0] load_all;
    logic [NUM_TMR-1:0][BUS_W-1:0] cnt_all;
    tmr_ctrl_t [NUM_TMR-1:0]       ctrl_all;
    logic [NUM_TMR-1:0]            load_wr_all;
    logic [NUM_TMR-1:0]            ctrl_wr_all;
    logic [NUM_TMR-1:0]            clr_all;
    logic [NUM_TMR-1:0]            uf_all;

    tmr_regif #(
        .BASES (BASES)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .load_rd (load_all),
        .cnt_rd  (cnt_all),
        .ctrl_rd (ctrl_all),
        .load_wr (load_wr_all),
        .ctrl_wr (ctrl_wr_all),
        .clr_wr  (clr_all),
        .rdata   (rdata)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        localparam int CH_W = (g == WIDE_IX) ? LARGE_W : SMALL_W;
        tmr_channel #(
            .WIDTH (CH_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .load_wr   (load_wr_all[g]),
            .ctrl_wr   (ctrl_wr_all[g]),
            .clr_wr    (clr_all[g]),
            .wdata     (wdata),
            .load_ext  (load_all[g]),
            .cnt_ext   (cnt_all[g]),
            .ctrl_o    (ctrl_all[g]),
            .irq_o     (irq[g]),
            .uf_o      (uf_all[g])
        );
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [BUS_W-1:0]   rdata,
    input logic [NUM_TMR-1:0] irq,
    input logic [NUM_TMR-1:0] uf_all,
    input logic [NUM_TMR-1:0] clr_all
);

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
        // R7 / R8: an underflow leaves the interrupt pending
        a_r7_uf_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
            uf_all[g] |=> irq[g]);
        // R9: a clear without underflow drops the interrupt
        a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            clr_all[g] && !uf_all[g] |=> !irq[g]);
        // R9: pending interrupt holds until cleared
        a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] && !clr_all[g] |=> irq[g]);
        // R10: underflow beats a same-cycle clear
        a_r10_uf_wins: assert property (@(posedge clk) disable iff (!rst_n)
            uf_all[g] && clr_all[g] |=> irq[g]);
        // R7: no interrupt appears without an underflow
        a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !irq[g] && !uf_all[g] |=> !irq[g]);
    end

    // R3: the 16-bit value of timer 0 reads zero-extended
    a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == 8'h04 |=> rdata[31:16] == 16'h0000);
    // R5: control reads expose only bits 7, 6 and 3
    a_r5_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr[3:0] == 4'h8 |=> (rdata & ~32'h0000_00C8) == 32'h0);

endmodule

bind tmr_bank tmr_bank_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .irq     (irq),
    .uf_all  (uf_all),
    .clr_all (clr_all)
);

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .irq       (irq)
    );

    function automatic logic [7:0] base_of(input int t);
        return (t == 0) ? 8'h00 : (t == 1) ? 8'h20 : 8'h80;
    endfunction

    function automatic logic [31:0] ones_of(input int t);
        return (t == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input bit fast, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {29'b0, irq}, 32'h0);
        for (int t = 0; t < 3; t++) begin
            rd(base_of(t) + 8'h4, v); check("R1 value", v, 32'h0);
            rd(base_of(t) + 8'h8, v); check("R1 ctrl", v, 32'h0);
            rd(base_of(t) + 8'h0, v); check("R1 load", v, 32'h0);
        end

        // R7 / R4 / R2: periodic sweep on every timer
        for (int t = 0; t < 3; t++) begin
            for (int L = 0; L < 6; L++) begin
                wr(base_of(t) + 8'h8, 32'h0);
                wr(base_of(t) + 8'h0, L);
                rd(base_of(t) + 8'h4, v); check("R4 load copies to count", v, L);
                wr(base_of(t) + 8'h8, 32'hC8);
                pulse(1'b1, L);
                rd(base_of(t) + 8'h4, v); check("R6 count at zero", v, 32'h0);
                check("R7 no irq before underflow", {29'b0, irq}, 32'h0);
                pulse(1'b1, 1);
                check("R7 irq after L+1 ticks", {29'b0, irq}, 32'(1 << t));
                rd(base_of(t) + 8'h4, v); check("R7 reload", v, L);
                wr(base_of(t) + 8'hC, 32'h0);
                check("R9 clear", {29'b0, irq}, 32'h0);
            end
            wr(base_of(t) + 8'h8, 32'h0);
        end

        // R8 / R3: free-run wrap to the timer's own width
        for (int t = 0; t < 3; t++) begin
            wr(base_of(t) + 8'h0, 32'h2);
            wr(base_of(t) + 8'h8, 32'h88);
            pulse(1'b1, 3);
            rd(base_of(t) + 8'h4, v); check("R8 R3 wrap value", v, ones_of(t));
            check("R8 irq", {29'b0, irq}, 32'(1 << t));
            pulse(1'b1, 1);
            rd(base_of(t) + 8'h4, v); check("R8 counts on after wrap", v, ones_of(t) - 1);
            wr(base_of(t) + 8'hC, 32'hDEAD_BEEF);
            wr(base_of(t) + 8'h8, 32'h0);
        end

        // R3: 16-bit load truncates and reads zero-extended
        wr(8'h20, 32'h1234_ABCD);
        rd(8'h20, v); check("R3 load width t1", v, 32'h0000_ABCD);
        wr(8'h80, 32'h1234_ABCD);
        rd(8'h84, v); check("R3 R2 value t2", v, 32'h1234_ABCD);

        // R5: control readback mask
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); check("R5 ctrl mask", v, 32'hC8);
        wr(8'h08, 32'h0);

        // R6: clock select and enable
        wr(8'h00, 32'd10);
        wr(8'h08, 32'hC8);
        pulse(1'b0, 3);
        rd(8'h04, v); check("R6 slow ignored when fast selected", v, 32'd10);
        wr(8'h08, 32'hC0);
        pulse(1'b0, 2);
        pulse(1'b1, 4);
        rd(8'h04, v); check("R6 slow select counts slow only", v, 32'd8);
        wr(8'h08, 32'h48);
        pulse(1'b1, 3);
        rd(8'h04, v); check("R6 disabled holds", v, 32'd8);

        // R4: load write wins over same-cycle tick
        wr(8'h08, 32'hC8);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h00; wdata = 32'd7; tick_fast = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_fast = 1'b0;
        rd(8'h04, v); check("R4 load beats tick", v, 32'd7);

        // R10: underflow wins over same-cycle clear
        wr(8'h00, 32'd0);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h0C; wdata = 32'h0; tick_fast = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_fast = 1'b0;
        check("R10 irq stays", {29'b0, irq}, 32'h1);

        // R9: clearing one timer leaves another pending
        wr(8'h20, 32'd0);
        wr(8'h28, 32'hC8);
        wr(8'h08, 32'h0);
        pulse(1'b1, 1);
        check("R9 two pending", {29'b0, irq}, 32'h3);
        wr(8'h2C, 32'h5);
        check("R9 only timer1 cleared", {29'b0, irq}, 32'h1);
        repeat (3) @(negedge clk);
        check("R9 pending holds", {29'b0, irq}, 32'h1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule